// File: doc/BRIEF.md
# Processor exception entry unit

This block performs the register side of taking an exception in a 32-bit core with a branch-delay slot. When the pipeline raises an exception it presents one request: the kind of fault, its 5-bit cause code, the PC of the faulting instruction, the PC that was due to follow it, and the current Status, shadow-set control and Cause register values. One clock edge later the block returns the updated Status, shadow-set control, Cause and EPC values together with the address to fetch from next, marked by a one-cycle redirect strobe.

The request side is a valid/ready stream. `req_ready` is held high, so the block never applies back-pressure: every cycle in which `req_valid` is high is a transfer, and the result of each transfer appears on the next edge. The block keeps no queue, so back-to-back requests give back-to-back results. Power-on reset requests take a separate path that leaves the exception bookkeeping untouched. Soft-reset and non-maskable-interrupt requests are not supported and produce an error strobe and no state change.

Top module: `exc_entry_unit`

## Requirements
- R1: `req_ready` is always 1. A request with `req_valid` high commits on that clock edge. Its register results and the one-cycle `redirect_valid` strobe are visible from the next edge.
- R2: `req_kind` encoding: 0 interrupt, 1 power-on reset, 2 soft reset, 3 NMI, 4..15 the other faults. Interrupt takes offset 0x000 and kinds 4..15 take offset 0x180. The redirect address is the base plus the offset, where the base is 0x80000000 when Status bit 22 (BEV) is 0 and 0xBFC00200 when it is 1.
- R3: A power-on reset request (kind 1) redirects to 0xBFC00000 and sets Status bit 29 (coprocessor 1 usable), keeping the other Status bits. The shadow-set, Cause and EPC outputs take the request's input values unchanged, and EPC takes the request PC.
- R4: A soft reset or NMI request (kind 2 or 3) raises `unsupported_err` for one cycle and leaves `redirect_valid` low. Every register output keeps its previous value.
- R5: For every exception kind (0 and 4..15), Status bit 1 (EXL) is set in the output whatever its input value, and all other Status bits pass through.
- R6: For exception kinds, the shadow-set control fields rotate only when input EXL and BEV are both 0. In that case the previous set (bits 9:6) takes the current set (bits 3:0), the current set takes the exception set (bits 15:12), and the other bits are kept. Otherwise the register passes through unchanged.
- R7: For exception kinds, the instruction is in a delay slot when the next PC differs from PC+4. In that case Cause bit 31 (BD) is 1 and EPC is PC-4. Otherwise BD is 0 and EPC is PC.
- R8: For exception kinds, Cause bits 6:2 take `req_code`, Cause bits 29:28 (CE) are cleared, and all other Cause bits pass through.
- R9: During reset and after it, before any request, all register outputs are 0 and both strobes are low.
- R10: In a cycle without `req_valid`, both strobes are low on the next edge and every register output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Always high; request accepted |
| req_kind | input | 4 | Fault kind (encoding in R2) |
| req_code | input | 5 | Cause code to record |
| req_pc | input | 32 | PC of the faulting instruction |
| req_npc | input | 32 | PC scheduled after it |
| status_in | input | 32 | Current Status register |
| srsctl_in | input | 32 | Current shadow-set control register |
| cause_in | input | 32 | Current Cause register |
| status_out | output | 32 | Updated Status |
| srsctl_out | output | 32 | Updated shadow-set control |
| cause_out | output | 32 | Updated Cause |
| epc_out | output | 32 | Updated EPC |
| redirect_valid | output | 1 | One-cycle strobe: new fetch address valid |
| redirect_pc | output | 32 | New fetch address |
| unsupported_err | output | 1 | One-cycle strobe: request kind not handled |

## Verification
The cases that are hardest to reach are those where several conditions meet: an exception from a delay slot while EXL or BEV is already set, where BD and the EPC back-up must happen but the shadow-set rotation must not. The bench sweeps every request kind against all four EXL/BEV combinations, with and without a delay slot and with distinct shadow-set field values. Each soft-reset or NMI request is placed right after a committed exception, so the outputs it must not touch hold known, non-zero values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // Request kind encoding
  localparam logic [3:0] KIND_INTERRUPT  = 4'd0;
  localparam logic [3:0] KIND_POR        = 4'd1;
  localparam logic [3:0] KIND_SOFT_RESET = 4'd2;
  localparam logic [3:0] KIND_NMI        = 4'd3;

  // Status bit positions
  localparam int ST_EXL = 1;
  localparam int ST_BEV = 22;
  localparam int ST_CU1 = 29;

  // Cause field positions
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_W  = 5;
  localparam int CA_CE_LO   = 28;
  localparam int CA_CE_W    = 2;
  localparam int CA_BD      = 31;

  // Shadow-set control field positions
  localparam int SS_W      = 4;
  localparam int SS_CUR_LO = 0;
  localparam int SS_PRV_LO = 6;
  localparam int SS_EXC_LO = 12;

  typedef enum logic [1:0] {
    PATH_EXC,
    PATH_POR,
    PATH_UNSUP
  } entry_path_e;
endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter logic [31:0] BASE_NORMAL = 32'h8000_0000,
  parameter logic [31:0] BASE_BOOT   = 32'hBFC0_0200,
  parameter logic [31:0] POR_VECTOR  = 32'hBFC0_0000,
  parameter logic [11:0] OFS_GENERAL = 12'h180
) (
  input  logic [3:0]      kind,
  input  logic            bev,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base   = bev ? XLEN'(BASE_BOOT) : XLEN'(BASE_NORMAL);
    offset = (kind == KIND_INTERRUPT) ? '0 : XLEN'(OFS_GENERAL);
    if (kind == KIND_POR) target = XLEN'(POR_VECTOR);
    else                  target = base + offset;
  end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [3:0]      kind,
  input  logic [4:0]      code,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] npc,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] srsctl_i,
  input  logic [XLEN-1:0] cause_i,
  output entry_path_e     path,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] srsctl_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic in_slot;
  logic rotate;

  always_comb begin
    unique case (kind)
      KIND_POR:                  path = PATH_POR;
      KIND_SOFT_RESET, KIND_NMI: path = PATH_UNSUP;
      default:                   path = PATH_EXC;
    endcase
  end

  assign in_slot = (npc != pc + STEP);
  assign rotate  = !status_i[ST_EXL] && !status_i[ST_BEV];

  always_comb begin
    status_o = status_i;
    srsctl_o = srsctl_i;
    cause_o  = cause_i;
    epc_o    = pc;
    if (path == PATH_POR) begin
      status_o[ST_CU1] = 1'b1;
    end else begin
      status_o[ST_EXL] = 1'b1;
      if (rotate) begin
        srsctl_o[SS_PRV_LO +: SS_W] = srsctl_i[SS_CUR_LO +: SS_W];
        srsctl_o[SS_CUR_LO +: SS_W] = srsctl_i[SS_EXC_LO +: SS_W];
      end
      cause_o[CA_CODE_LO +: CA_CODE_W] = code;
      cause_o[CA_CE_LO +: CA_CE_W]     = '0;
      cause_o[CA_BD]                   = in_slot;
      epc_o = in_slot ? pc - STEP : pc;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [3:0]      req_kind,
  input  logic [4:0]      req_code,
  input  logic [XLEN-1:0] req_pc,
  input  logic [XLEN-1:0] req_npc,
  input  logic [XLEN-1:0] status_in,
  input  logic [XLEN-1:0] srsctl_in,
  input  logic [XLEN-1:0] cause_in,
  output logic [XLEN-1:0] status_out,
  output logic [XLEN-1:0] srsctl_out,
  output logic [XLEN-1:0] cause_out,
  output logic [XLEN-1:0] epc_out,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            unsupported_err
);
  entry_path_e     path;
  logic [XLEN-1:0] nx_status, nx_srsctl, nx_cause, nx_epc, nx_target;
  logic            commit;

  assign req_ready = 1'b1;

  exc_state_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) calc_i (
    .kind(req_kind), .code(req_code), .pc(req_pc), .npc(req_npc),
    .status_i(status_in), .srsctl_i(srsctl_in), .cause_i(cause_in),
    .path(path), .status_o(nx_status), .srsctl_o(nx_srsctl),
    .cause_o(nx_cause), .epc_o(nx_epc)
  );

  exc_vector_sel #(.XLEN(XLEN)) vec_i (
    .kind(req_kind), .bev(status_in[ST_BEV]), .target(nx_target)
  );

  assign commit = req_valid && req_ready && (path != PATH_UNSUP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_out      <= '0;
      srsctl_out      <= '0;
      cause_out       <= '0;
      epc_out         <= '0;
      redirect_pc     <= '0;
      redirect_valid  <= 1'b0;
      unsupported_err <= 1'b0;
    end else begin
      redirect_valid  <= commit;
      unsupported_err <= req_valid && (path == PATH_UNSUP);
      if (commit) begin
        status_out  <= nx_status;
        srsctl_out  <= nx_srsctl;
        cause_out   <= nx_cause;
        epc_out     <= nx_epc;
        redirect_pc <= nx_target;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_kind,
  input logic [4:0]  req_code,
  input logic [31:0] req_pc,
  input logic [31:0] req_npc,
  input logic [31:0] status_in,
  input logic [31:0] srsctl_in,
  input logic [31:0] cause_in,
  input logic [31:0] status_out,
  input logic [31:0] srsctl_out,
  input logic [31:0] cause_out,
  input logic [31:0] epc_out,
  input logic        redirect_valid,
  input logic [31:0] redirect_pc,
  input logic        unsupported_err
);
  logic is_exc;
  assign is_exc = req_valid && (req_kind == 4'd0 || req_kind >= 4'd4);

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

  assert_no_req_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !redirect_valid && !unsupported_err && $stable(epc_out) && $stable(status_out));

  assert_por_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 4'd1) |=> redirect_valid && redirect_pc == 32'hBFC0_0000 && status_out[29]);

  assert_unsup_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 4'd2 || req_kind == 4'd3)) |=>
      unsupported_err && !redirect_valid && $stable(cause_out) && $stable(srsctl_out));

  assert_exl_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_exc |=> status_out[1] && redirect_valid);

  assert_srs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_exc && (status_in[1] || status_in[22])) |=> srsctl_out == $past(srsctl_in));

  assert_slot_epc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_exc && req_npc != req_pc + 32'd4) |=> cause_out[31] && epc_out == $past(req_pc) - 32'd4);

  assert_ce_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_exc |=> cause_out[29:28] == 2'b00 && cause_out[6:2] == $past(req_code));

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_valid && unsupported_err));
endmodule

bind exc_entry_unit exc_entry_unit_chk chk_i (.*);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_kind = '0;
  logic [4:0]  req_code = '0;
  logic [31:0] req_pc = '0, req_npc = '0;
  logic [31:0] status_in = '0, srsctl_in = '0, cause_in = '0;
  logic [31:0] status_out, srsctl_out, cause_out, epc_out, redirect_pc;
  logic        redirect_valid, unsupported_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected (last committed) register state
  logic [31:0] e_status = '0, e_srs = '0, e_cause = '0, e_epc = '0, e_pc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk({req, " status"}, status_out, e_status);
    chk({req, " srsctl"}, srsctl_out, e_srs);
    chk({req, " cause"},  cause_out,  e_cause);
    chk({req, " epc"},    epc_out,    e_epc);
  endtask

  // Drive one request, compute expected result, check one cycle later.
  task automatic do_req(input logic [3:0] k, input logic [4:0] c, input logic [31:0] pc,
                        input logic slot, input logic [31:0] st, input logic [31:0] ss,
                        input logic [31:0] ca);
    logic [31:0] npc, base;
    logic unsup;
    npc = slot ? pc + 32'd100 : pc + 32'd4;
    unsup = (k == 4'd2 || k == 4'd3);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_code = c; req_pc = pc; req_npc = npc;
    status_in = st; srsctl_in = ss; cause_in = ca;
    if (k == 4'd1) begin
      e_status = st | 32'h2000_0000; e_srs = ss; e_cause = ca; e_epc = pc;
      e_pc = 32'hBFC0_0000;
    end else if (!unsup) begin
      e_status = st | 32'h2;
      e_srs = ss;
      if (st[1] == 1'b0 && st[22] == 1'b0)
        e_srs = (ss & ~32'h0000_03CF) | {22'd0, ss[3:0], 2'b00, ss[15:12]};
      e_cause = (ca & ~32'hB000_007C) | {slot, 24'd0, c, 2'b00};
      e_epc = slot ? pc - 32'd4 : pc;
      base = st[22] ? 32'hBFC0_0200 : 32'h8000_0000;
      e_pc = base + ((k == 4'd0) ? 32'h0 : 32'h180);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (unsup) begin
      chk("R4 err", {31'd0, unsupported_err}, 32'd1);
      chk("R4 no redirect", {31'd0, redirect_valid}, 32'd0);
      check_regs("R4 hold");
    end else begin
      chk("R1 strobe", {31'd0, redirect_valid}, 32'd1);
      chk("R1 err low", {31'd0, unsupported_err}, 32'd0);
      chk(k == 4'd1 ? "R3 vector" : "R2 vector", redirect_pc, e_pc);
      check_regs(k == 4'd1 ? "R3" : "R5 R6 R7 R8");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_regs("R9 in reset");
    chk("R9 strobes", {30'd0, redirect_valid, unsupported_err}, 32'd0);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R9 after reset");
    chk("R9 strobes after", {30'd0, redirect_valid, unsupported_err}, 32'd0);

    for (int k = 0; k < 16; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] st, ss, ca, pc;
          st = 32'h0000_FF00 | (m[0] ? 32'h2 : 32'h0) | (m[1] ? 32'h0040_0000 : 32'h0);
          ss = 32'h0000_0000 | {16'd0, 4'(k + 3), 8'd0, 4'(m + 9)} | 32'h0003_0000;
          ca = 32'h3000_0F83 ^ {27'd0, 5'(k)};
          pc = 32'h0040_1000 + 32'(k * 64 + m * 8 + s * 4);
          if (k == 2 || k == 3)  // prime known non-zero state first
            do_req(4'd5, 5'(k + m), pc + 32'h100, 1'b1, st, ss, ca);
          do_req(4'(k), 5'(k * 2 + m + s), pc, s[0], st, ss, ca);
        end
      end
      // idle cycle: nothing may change
      @(negedge clk);
      chk("R10 strobes idle", {30'd0, redirect_valid, unsupported_err}, 32'd0);
      check_regs("R10 hold");
    end

    // boundary: PC at zero with delay slot wraps EPC
    do_req(4'd8, 5'd31, 32'h0, 1'b1, 32'h0, 32'h0000_F00F, 32'hFFFF_FFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule